// File: doc/BRIEF.md
# Interrupt Source Register Decoder

This block sits between a 32-bit memory-mapped register port and an array of interrupt source gateways. It decodes each word-aligned access into one of several register groups and turns writes into one-cycle command strobes toward the gateways. The groups are a domain control word, per-source mode and routing arrays, bit-vector arrays that set or clear pending and enable flags, and number registers that act on a single named source. The per-source state lives outside the block. The gateways present their pending, enable, rectified-input, mode and routing values as flat input vectors, and reads assemble words from those vectors, 32 sources to a word.

Sources are numbered 1 to `NSRC`. Source 0 does not exist, so bit 0 of the first vector word is never acted on and always reads as zero. Every access gets a response one cycle after it is presented. An access gets an error response with zero data when any of the following holds:
- it is not word-aligned;
- it is not 4 bytes wide;
- it targets an offset that no group claims.

An access that gets an error has no side effect. The block stores only two things of its own: the domain interrupt-enable bit and a message-generation word that reads back as written, with its guest field cleared.

Top module: `irq_reg_decoder`

## Requirements
- R1: An access with `addr_i[1:0]` not zero, or with `size_i` not 2 (log2 of 4 bytes), responds with error set and zero data, and raises no strobe and changes no stored state.
- R2: An aligned 4-byte access to an offset outside every group responds with error set and zero data. Examples are 0x1C00 plus 4 times the word count, 0x0004 plus 4 times NSRC, and 0x0FF0.
- R3: Every access is answered by `rsp_vld_o` high for exactly the one cycle after the request cycle.
- R4: The domain word at 0x0000 has only bit 8 (interrupt enable) writable, and that bit is driven on `dom_ie_o`. A read returns 0x8000_0004 OR (enable << 8). The enable changes only on a write.
- R5: Mode entry k at 0x0004 + 4k, for k from 0 to NSRC-1, belongs to source k+1. A read returns `cfg_i` slice k (11 bits). A write pulses `cfg_we_o[k+1]` and drives `cfg_wdata_o`, which is 0 when write bit 10 (delegate) is set and otherwise the low 3 mode bits.
- R6: Routing entry k at 0x3004 + 4k belongs to source k+1. A read returns `tgt_i` slice k. A write pulses `tgt_we_o[k+1]` with data masked by 0xFFFF_F7FF, which keeps the identity field [10:0], the guest field [17:12] and the hart field [31:18].
- R7: A write of word w to the bit arrays acts on source 32w+b for each set bit b, skipping source 0 and sources above NSRC. The arrays are set-pending at 0x1C00, clear-pending at 0x1D00, set-enable at 0x1E00 and clear-enable at 0x1F00, each one word count long, and the word count is ceil((NSRC+1)/32).
- R8: Reading the set-pending array returns pending bits. Reading the clear-pending array returns rectified input bits. Reading the set-enable array returns enable bits. Reading the clear-enable array returns zero.
- R9: A write to the number registers acts on the one source equal to the written value, and only if that value lies in 1..NSRC. The registers are set-pending at 0x1CDC, clear-pending at 0x1DDC, set-enable at 0x1EDC and clear-enable at 0x1FDC. All four read as zero.
- R10: The number register at 0x2000 sets pending exactly like 0x1CDC. The one at 0x2004 byte-reverses the written value before using it as the source number. Both read as zero.
- R11: The message word at 0x3000 stores a write with bits 17:12 cleared, and a read returns the stored value.
- R12: Command strobes are one-cycle pulses in the cycle after a write that did not get an error, and reads raise none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | log2 of access size in bytes; only 2 is accepted |
| addr_i | input | AW | Byte offset inside the register window |
| wdata_i | input | 32 | Write data |
| rsp_vld_o | output | 1 | Response valid, one cycle after request |
| rsp_err_o | output | 1 | Error response |
| rsp_rdata_o | output | 32 | Read data, zero on error or write |
| pend_i | input | NSRC | Pending flag of sources 1..NSRC |
| en_i | input | NSRC | Enable flag of sources 1..NSRC |
| rin_i | input | NSRC | Rectified input of sources 1..NSRC |
| cfg_i | input | NSRC*11 | Mode values, source k+1 at slice k |
| tgt_i | input | NSRC*32 | Routing values, source k+1 at slice k |
| dom_ie_o | output | 1 | Domain interrupt enable |
| set_pend_o | output | NSRC | Set-pending strobes |
| clr_pend_o | output | NSRC | Clear-pending strobes |
| set_en_o | output | NSRC | Set-enable strobes |
| clr_en_o | output | NSRC | Clear-enable strobes |
| cfg_we_o | output | NSRC | Mode write strobes |
| cfg_wdata_o | output | 11 | Filtered mode write value |
| tgt_we_o | output | NSRC | Routing write strobes |
| tgt_wdata_o | output | 32 | Masked routing write value |

## Verification
Every result of an access is due in the one cycle after the request edge. This covers the response flags and data, every strobe, the filtered write data and the domain enable. The bench drives the request on a falling edge and samples all outputs on the next falling edge. At that point the results of the access stand and the request has been withdrawn, so nothing from the following access can appear. The gateway state inputs change together with the request, so read data is checked against the values that were present at the request edge. An extra idle cycle after selected writes confirms that the strobes and the valid flag have dropped again.

// File: rtl/irqdec_pkg.sv
package irqdec_pkg;

  localparam int unsigned CFG_W       = 11;
  localparam int unsigned CFG_DLG_BIT = 10;
  localparam int unsigned DOM_IE_BIT  = 8;

  localparam logic [CFG_W-1:0] CFG_MODE_MASK  = 11'h007;
  localparam logic [31:0]      TGT_KEEP_MASK  = 32'hFFFF_F7FF;
  localparam logic [31:0]      MSI_GUEST_MASK = 32'h0003_F000;
  localparam logic [31:0]      DOM_FIXED      = 32'h8000_0004;

  localparam logic [31:0] OFS_DOM      = 32'h0000_0000;
  localparam logic [31:0] OFS_CFG      = 32'h0000_0004;
  localparam logic [31:0] OFS_SETIP    = 32'h0000_1C00;
  localparam logic [31:0] OFS_SETIPNUM = 32'h0000_1CDC;
  localparam logic [31:0] OFS_CLRIP    = 32'h0000_1D00;
  localparam logic [31:0] OFS_CLRIPNUM = 32'h0000_1DDC;
  localparam logic [31:0] OFS_SETIE    = 32'h0000_1E00;
  localparam logic [31:0] OFS_SETIENUM = 32'h0000_1EDC;
  localparam logic [31:0] OFS_CLRIE    = 32'h0000_1F00;
  localparam logic [31:0] OFS_CLRIENUM = 32'h0000_1FDC;
  localparam logic [31:0] OFS_NUM_LE   = 32'h0000_2000;
  localparam logic [31:0] OFS_NUM_BE   = 32'h0000_2004;
  localparam logic [31:0] OFS_MSI      = 32'h0000_3000;
  localparam logic [31:0] OFS_TGT      = 32'h0000_3004;

  typedef enum logic [3:0] {
    RG_NONE, RG_DOM, RG_CFG, RG_SETIP, RG_SETIPNUM, RG_CLRIP, RG_CLRIPNUM,
    RG_SETIE, RG_SETIENUM, RG_CLRIE, RG_CLRIENUM, RG_NUM_LE, RG_NUM_BE,
    RG_MSI, RG_TGT
  } region_e;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [CFG_W-1:0] cfg_filter(input logic [31:0] v);
    return v[CFG_DLG_BIT] ? '0 : (v[CFG_W-1:0] & CFG_MODE_MASK);
  endfunction

  function automatic logic [31:0] tgt_filter(input logic [31:0] v);
    return v & TGT_KEEP_MASK;
  endfunction

  function automatic logic [31:0] msi_filter(input logic [31:0] v);
    return v & ~MSI_GUEST_MASK;
  endfunction

  function automatic logic [31:0] dom_read(input logic ie);
    return DOM_FIXED | (32'(ie) << DOM_IE_BIT);
  endfunction

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] base,
                                  input logic [31:0] span);
    return (a >= base) && (a < base + span);
  endfunction

endpackage

// File: rtl/irqdec_decode.sv
module irqdec_decode
  import irqdec_pkg::*;
#(
  parameter int unsigned AW     = 15,
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NWORDS = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  output region_e       region_o,
  output logic [AW-1:0] idx_o,
  output logic          fault_o
);

  localparam logic [31:0] SRC_SPAN  = 32'(4 * NSRC);
  localparam logic [31:0] WORD_SPAN = 32'(4 * NWORDS);

  logic [31:0] a;
  logic [31:0] base;
  assign a = 32'(addr_i);

  assign fault_o = (size_i != 2'd2) || (addr_i[1:0] != 2'b00);

  always_comb begin
    region_o = RG_NONE;
    base     = '0;
    if (a == OFS_DOM)                         region_o = RG_DOM;
    else if (in_win(a, OFS_CFG, SRC_SPAN))    begin region_o = RG_CFG;   base = OFS_CFG;   end
    else if (in_win(a, OFS_SETIP, WORD_SPAN)) begin region_o = RG_SETIP; base = OFS_SETIP; end
    else if (a == OFS_SETIPNUM)               region_o = RG_SETIPNUM;
    else if (in_win(a, OFS_CLRIP, WORD_SPAN)) begin region_o = RG_CLRIP; base = OFS_CLRIP; end
    else if (a == OFS_CLRIPNUM)               region_o = RG_CLRIPNUM;
    else if (in_win(a, OFS_SETIE, WORD_SPAN)) begin region_o = RG_SETIE; base = OFS_SETIE; end
    else if (a == OFS_SETIENUM)               region_o = RG_SETIENUM;
    else if (in_win(a, OFS_CLRIE, WORD_SPAN)) begin region_o = RG_CLRIE; base = OFS_CLRIE; end
    else if (a == OFS_CLRIENUM)               region_o = RG_CLRIENUM;
    else if (a == OFS_NUM_LE)                 region_o = RG_NUM_LE;
    else if (a == OFS_NUM_BE)                 region_o = RG_NUM_BE;
    else if (a == OFS_MSI)                    region_o = RG_MSI;
    else if (in_win(a, OFS_TGT, SRC_SPAN))    begin region_o = RG_TGT;   base = OFS_TGT;   end
  end

  logic [31:0] rel;
  assign rel   = (a - base) >> 2;
  assign idx_o = rel[AW-1:0];

endmodule

// File: rtl/irqdec_rdmux.sv
module irqdec_rdmux
  import irqdec_pkg::*;
#(
  parameter int unsigned AW     = 15,
  parameter int unsigned NSRC   = 40,
  parameter int unsigned NWORDS = 2
) (
  input  region_e               region_i,
  input  logic [AW-1:0]         idx_i,
  input  logic                  ie_i,
  input  logic [31:0]           msi_i,
  input  logic [NSRC:1]         pend_i,
  input  logic [NSRC:1]         en_i,
  input  logic [NSRC:1]         rin_i,
  input  logic [NSRC*CFG_W-1:0] cfg_i,
  input  logic [NSRC*32-1:0]    tgt_i,
  output logic [31:0]           rdata_o
);

  localparam int unsigned PADW = NWORDS * 32;
  localparam int unsigned WIW  = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int unsigned SIW  = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [PADW-1:0] pend_pad, en_pad, rin_pad;

  always_comb begin
    pend_pad = '0;
    en_pad   = '0;
    rin_pad  = '0;
    pend_pad[NSRC:1] = pend_i;
    en_pad[NSRC:1]   = en_i;
    rin_pad[NSRC:1]  = rin_i;
  end

  logic [31:0] pend_w [NWORDS];
  logic [31:0] en_w   [NWORDS];
  logic [31:0] rin_w  [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign pend_w[w] = pend_pad[w*32 +: 32];
    assign en_w[w]   = en_pad[w*32 +: 32];
    assign rin_w[w]  = rin_pad[w*32 +: 32];
  end

  logic [CFG_W-1:0] cfg_a [NSRC];
  logic [31:0]      tgt_a [NSRC];

  for (genvar k = 0; k < NSRC; k++) begin : g_entry
    assign cfg_a[k] = cfg_i[k*CFG_W +: CFG_W];
    assign tgt_a[k] = tgt_i[k*32 +: 32];
  end

  logic [WIW-1:0] widx;
  logic [SIW-1:0] sidx;
  assign widx = idx_i[WIW-1:0];
  assign sidx = idx_i[SIW-1:0];

  always_comb begin
    unique case (region_i)
      RG_DOM:   rdata_o = dom_read(ie_i);
      RG_CFG:   rdata_o = 32'(cfg_a[sidx]);
      RG_SETIP: rdata_o = pend_w[widx];
      RG_CLRIP: rdata_o = rin_w[widx];
      RG_SETIE: rdata_o = en_w[widx];
      RG_MSI:   rdata_o = msi_i;
      RG_TGT:   rdata_o = tgt_a[sidx];
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irqdec_wrstb.sv
module irqdec_wrstb
  import irqdec_pkg::*;
#(
  parameter int unsigned AW   = 15,
  parameter int unsigned NSRC = 40
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  region_e       region_i,
  input  logic [AW-1:0] idx_i,
  input  logic [31:0]   wdata_i,
  output logic [NSRC:1] set_pend_o,
  output logic [NSRC:1] clr_pend_o,
  output logic [NSRC:1] set_en_o,
  output logic [NSRC:1] clr_en_o,
  output logic [NSRC:1] cfg_we_o,
  output logic [NSRC:1] tgt_we_o
);

  logic [31:0] num_val;
  logic        num_setip, num_reg;

  assign num_val   = (region_i == RG_NUM_BE) ? bswap32(wdata_i) : wdata_i;
  assign num_setip = (region_i == RG_SETIPNUM) || (region_i == RG_NUM_LE) ||
                     (region_i == RG_NUM_BE);
  assign num_reg   = num_setip || (region_i == RG_CLRIPNUM) ||
                     (region_i == RG_SETIENUM) || (region_i == RG_CLRIENUM);

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    localparam int unsigned WI = s / 32;
    localparam int unsigned BI = s % 32;
    logic word_hit, num_hit, ent_hit;
    assign word_hit = (idx_i == AW'(WI)) && wdata_i[BI];
    assign num_hit  = (num_val == 32'(s));
    assign ent_hit  = (idx_i == AW'(s - 1));

    assign set_pend_o[s] = go_i && (((region_i == RG_SETIP) && word_hit) ||
                                    (num_setip && num_hit));
    assign clr_pend_o[s] = go_i && (((region_i == RG_CLRIP) && word_hit) ||
                                    ((region_i == RG_CLRIPNUM) && num_hit));
    assign set_en_o[s]   = go_i && (((region_i == RG_SETIE) && word_hit) ||
                                    ((region_i == RG_SETIENUM) && num_hit));
    assign clr_en_o[s]   = go_i && (((region_i == RG_CLRIE) && word_hit) ||
                                    ((region_i == RG_CLRIENUM) && num_hit));
    assign cfg_we_o[s]   = go_i && (region_i == RG_CFG) && ent_hit;
    assign tgt_we_o[s]   = go_i && (region_i == RG_TGT) && ent_hit;
  end

  // R9
  numreg_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && num_reg) |-> $onehot0(set_pend_o | clr_pend_o | set_en_o | clr_en_o));

endmodule

// File: rtl/irq_reg_decoder.sv
module irq_reg_decoder
  import irqdec_pkg::*;
#(
  parameter int unsigned NSRC = 40,
  parameter int unsigned AW   = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [1:0]            size_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [31:0]           wdata_i,
  output logic                  rsp_vld_o,
  output logic                  rsp_err_o,
  output logic [31:0]           rsp_rdata_o,
  input  logic [NSRC:1]         pend_i,
  input  logic [NSRC:1]         en_i,
  input  logic [NSRC:1]         rin_i,
  input  logic [NSRC*CFG_W-1:0] cfg_i,
  input  logic [NSRC*32-1:0]    tgt_i,
  output logic                  dom_ie_o,
  output logic [NSRC:1]         set_pend_o,
  output logic [NSRC:1]         clr_pend_o,
  output logic [NSRC:1]         set_en_o,
  output logic [NSRC:1]         clr_en_o,
  output logic [NSRC:1]         cfg_we_o,
  output logic [CFG_W-1:0]      cfg_wdata_o,
  output logic [NSRC:1]         tgt_we_o,
  output logic [31:0]           tgt_wdata_o
);

  localparam int unsigned NWORDS = (NSRC + 1 + 31) / 32;

  region_e       region;
  logic [AW-1:0] idx;
  logic          acc_fault, acc_unmapped, acc_err, wr_go, rd_go;
  logic [31:0]   rd_word, msi_q;
  logic [NSRC:1] nx_sp, nx_cp, nx_se, nx_ce, nx_cw, nx_tw;

  irqdec_decode #(.AW(AW), .NSRC(NSRC), .NWORDS(NWORDS)) u_dec (
    .addr_i  (addr_i),
    .size_i  (size_i),
    .region_o(region),
    .idx_o   (idx),
    .fault_o (acc_fault)
  );

  assign acc_unmapped = (region == RG_NONE);
  assign acc_err      = acc_fault || acc_unmapped;
  assign wr_go        = req_i && we_i && !acc_err;
  assign rd_go        = req_i && !we_i && !acc_err;

  irqdec_rdmux #(.AW(AW), .NSRC(NSRC), .NWORDS(NWORDS)) u_rd (
    .region_i(region),
    .idx_i   (idx),
    .ie_i    (dom_ie_o),
    .msi_i   (msi_q),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .rin_i   (rin_i),
    .cfg_i   (cfg_i),
    .tgt_i   (tgt_i),
    .rdata_o (rd_word)
  );

  irqdec_wrstb #(.AW(AW), .NSRC(NSRC)) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (wr_go),
    .region_i  (region),
    .idx_i     (idx),
    .wdata_i   (wdata_i),
    .set_pend_o(nx_sp),
    .clr_pend_o(nx_cp),
    .set_en_o  (nx_se),
    .clr_en_o  (nx_ce),
    .cfg_we_o  (nx_cw),
    .tgt_we_o  (nx_tw)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rsp_vld_o   <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
      dom_ie_o    <= 1'b0;
      msi_q       <= '0;
      set_pend_o  <= '0;
      clr_pend_o  <= '0;
      set_en_o    <= '0;
      clr_en_o    <= '0;
      cfg_we_o    <= '0;
      tgt_we_o    <= '0;
      cfg_wdata_o <= '0;
      tgt_wdata_o <= '0;
    end else begin
      rsp_vld_o   <= req_i;
      rsp_err_o   <= req_i && acc_err;
      rsp_rdata_o <= rd_go ? rd_word : '0;
      set_pend_o  <= nx_sp;
      clr_pend_o  <= nx_cp;
      set_en_o    <= nx_se;
      clr_en_o    <= nx_ce;
      cfg_we_o    <= nx_cw;
      tgt_we_o    <= nx_tw;
      if (wr_go && region == RG_CFG) cfg_wdata_o <= cfg_filter(wdata_i);
      if (wr_go && region == RG_TGT) tgt_wdata_o <= tgt_filter(wdata_i);
      if (wr_go && region == RG_DOM) dom_ie_o <= wdata_i[DOM_IE_BIT];
      if (wr_go && region == RG_MSI) msi_q <= msi_filter(wdata_i);
    end
  end

  logic any_stb;
  assign any_stb = |{set_pend_o, clr_pend_o, set_en_o, clr_en_o, cfg_we_o, tgt_we_o};

  // R1
  fault_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_fault) |=> (rsp_err_o && rsp_rdata_o == 32'h0));

  // R1
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && acc_fault) |=> !any_stb);

  // R3
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_vld_o);

  // R12
  stb_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> $past(req_i && we_i));

  // R5
  cfg_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cfg_we_o) && $onehot0(tgt_we_o));

  // R4
  ie_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dom_ie_o) |-> $past(req_i && we_i));

  // R9
  numreg_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (region == RG_SETIPNUM || region == RG_CLRIPNUM ||
     region == RG_SETIENUM || region == RG_CLRIENUM)) |=> rsp_rdata_o == 32'h0);

endmodule

// File: tb/tb_irq_reg_decoder.sv
`timescale 1ns/1ps
module tb_irq_reg_decoder;

  localparam int NSRC = 40;
  localparam int AW   = 15;
  localparam int NW   = (NSRC + 32) / 32;
  localparam int CW   = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] sz = 2'd2;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rsp_vld, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NSRC:1] pend = '0, en = '0, rin = '0;
  logic [NSRC*CW-1:0] cfg = '0;
  logic [NSRC*32-1:0] tgt = '0;
  logic dom_ie;
  logic [NSRC:1] sp, cp, se, ce, cw, tw;
  logic [CW-1:0] cwd;
  logic [31:0] twd;

  irq_reg_decoder #(.NSRC(NSRC), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz),
    .addr_i(addr), .wdata_i(wdata), .rsp_vld_o(rsp_vld), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .pend_i(pend), .en_i(en), .rin_i(rin),
    .cfg_i(cfg), .tgt_i(tgt), .dom_ie_o(dom_ie), .set_pend_o(sp),
    .clr_pend_o(cp), .set_en_o(se), .clr_en_o(ce), .cfg_we_o(cw),
    .cfg_wdata_o(cwd), .tgt_we_o(tw), .tgt_wdata_o(twd)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_ie = 0;
  logic [31:0] m_msi = '0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] swap4(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = v[8*(3-i) +: 8];
    return r;
  endfunction

  // kinds: 0 none,1 dom,2 cfg,3 sip,4 sipn,5 cip,6 cipn,7 sie,8 sien,9 cie,10 cien,11 le,12 be,13 msi,14 tgt
  function automatic int kind_of(input int a);
    if (a == 0) return 1;
    if (a >= 4 && a < 4 + 4*NSRC) return 2;
    if (a >= 'h3004 && a < 'h3004 + 4*NSRC) return 14;
    if (a >= 'h1C00 && a < 'h1C00 + 4*NW) return 3;
    if (a >= 'h1D00 && a < 'h1D00 + 4*NW) return 5;
    if (a >= 'h1E00 && a < 'h1E00 + 4*NW) return 7;
    if (a >= 'h1F00 && a < 'h1F00 + 4*NW) return 9;
    case (a)
      'h1CDC: return 4;  'h1DDC: return 6;  'h1EDC: return 8;  'h1FDC: return 10;
      'h2000: return 11; 'h2004: return 12; 'h3000: return 13;
      default: return 0;
    endcase
  endfunction

  function automatic int base_of(input int k);
    case (k)
      2: return 4;  14: return 'h3004;
      3: return 'h1C00; 5: return 'h1D00; 7: return 'h1E00; 9: return 'h1F00;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2"; 1: return "R4"; 2: return "R5"; 14: return "R6";
      3, 5, 7, 9: return "R7"; 4, 6, 8, 10: return "R9";
      11, 12: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] vword(input logic [NSRC:1] v, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      int s = 32*w + b;
      if (s >= 1 && s <= NSRC) r[b] = v[s];
    end
    return r;
  endfunction

  task automatic rand_state();
    for (int s = 1; s <= NSRC; s++) begin
      pend[s] = $urandom_range(0, 1);
      en[s]   = $urandom_range(0, 1);
      rin[s]  = $urandom_range(0, 1);
    end
    for (int k = 0; k < NSRC; k++) begin
      cfg[k*CW +: CW] = CW'($urandom);
      tgt[k*32 +: 32] = $urandom;
    end
  endtask

  task automatic access(input bit w, input logic [1:0] s2, input int a, input logic [31:0] d);
    int k, e, num;
    bit bad, werr;
    string tg;
    logic [31:0] exp_rd;
    logic [NSRC:1] e_sp, e_cp, e_se, e_ce, e_cw, e_tw;
    @(negedge clk);
    rand_state();
    req = 1'b1; we = w; sz = s2; addr = AW'(a); wdata = d;
    k = kind_of(a);
    bad = (s2 != 2'd2) || (a % 4 != 0);
    werr = bad || (k == 0);
    tg = bad ? "R1" : tag_of(k);
    e = (a - base_of(k)) / 4;
    num = (k == 12) ? int'(swap4(d)) : int'(d);
    e_sp = '0; e_cp = '0; e_se = '0; e_ce = '0; e_cw = '0; e_tw = '0;
    exp_rd = '0;
    if (!werr && w) begin
      for (int s = 1; s <= NSRC; s++) begin
        bit wb = (s / 32 == e) && d[s % 32];
        bit nb = (num == s);
        if ((k == 3 && wb) || ((k == 4 || k == 11 || k == 12) && nb)) e_sp[s] = 1;
        if ((k == 5 && wb) || (k == 6 && nb)) e_cp[s] = 1;
        if ((k == 7 && wb) || (k == 8 && nb)) e_se[s] = 1;
        if ((k == 9 && wb) || (k == 10 && nb)) e_ce[s] = 1;
      end
      if (k == 2) e_cw[e+1] = 1;
      if (k == 14) e_tw[e+1] = 1;
    end else if (!werr) begin
      case (k)
        1: exp_rd = 32'h8000_0004 | (32'(m_ie) << 8);
        2: exp_rd = 32'(cfg[e*CW +: CW]);
        3: exp_rd = vword(pend, e);
        5: exp_rd = vword(rin, e);
        7: exp_rd = vword(en, e);
        13: exp_rd = m_msi;
        14: exp_rd = tgt[e*32 +: 32];
        default: exp_rd = '0;
      endcase
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    if (!werr && w && k == 1) m_ie = d[8];
    if (!werr && w && k == 13) m_msi = d & 32'hFFFC_0FFF;
    chk("R3", "rsp_vld", 64'(rsp_vld), 64'd1);
    chk(tg, "rsp_err", 64'(rsp_err), 64'(werr));
    chk(tg, "rdata", 64'(rsp_rdata), 64'(exp_rd));
    chk(tg, "set_pend", 64'(sp), 64'(e_sp));
    chk(tg, "clr_pend", 64'(cp), 64'(e_cp));
    chk(tg, "set_en", 64'(se), 64'(e_se));
    chk(tg, "clr_en", 64'(ce), 64'(e_ce));
    chk(tg, "cfg_we", 64'(cw), 64'(e_cw));
    chk(tg, "tgt_we", 64'(tw), 64'(e_tw));
    chk("R4", "dom_ie", 64'(dom_ie), 64'(m_ie));
    if (e_cw != 0) chk("R5", "cfg_wdata", 64'(cwd), 64'(d[10] ? 11'h0 : 11'(d & 7)));
    if (e_tw != 0) chk("R6", "tgt_wdata", 64'(twd), 64'(d & 32'hFFFF_F7FF));
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R12", "strobes idle", 64'(|{sp, cp, se, ce, cw, tw}), 64'd0);
    chk("R3", "rsp_vld idle", 64'(rsp_vld), 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int bases[15];
    void'($urandom(32'd1234));
    bases = '{0, 4, 'h1C00, 'h1CDC, 'h1D00, 'h1DDC, 'h1E00, 'h1EDC, 'h1F00,
              'h1FDC, 'h2000, 'h2004, 'h3000, 'h3004, 'h0FF0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R3 R4 R12
    chk("R3", "reset rsp_vld", 64'(rsp_vld), 64'd0);
    chk("R4", "reset dom_ie", 64'(dom_ie), 64'd0);
    chk("R12", "reset strobes", 64'(|{sp, cp, se, ce, cw, tw}), 64'd0);

    // R4 domain word
    access(0, 2, 0, 0);
    access(1, 2, 0, 32'hFFFF_FFFF);
    access(0, 2, 0, 0);
    access(1, 2, 0, 32'hFFFF_FEFF);
    access(0, 2, 0, 0);
    // R1 misaligned / wrong size
    access(1, 2, 'h1C01, 32'hFFFF_FFFF);
    access(1, 1, 'h1C00, 32'hFFFF_FFFF);
    access(0, 3, 0, 0);
    access(1, 0, 0, 32'h100);
    // R2 unmapped
    access(0, 2, 'h1C00 + 4*NW, 0);
    access(1, 2, 4 + 4*NSRC, 32'h5);
    access(0, 2, 'h0FF0, 0);
    // R5 config ends
    access(1, 2, 4, 32'h405);
    access(1, 2, 4 + 4*(NSRC-1), 32'h3FE);
    access(0, 2, 4 + 4*(NSRC-1), 0);
    // R6 target mask
    access(1, 2, 'h3004 + 8, 32'hFFFF_FFFF);
    access(0, 2, 'h3004 + 4*(NSRC-1), 0);
    // R7 word arrays with edges
    access(1, 2, 'h1C04, 32'hFFFF_FFFF);
    idle_check();
    access(1, 2, 'h1C00, 32'h1);
    access(1, 2, 'h1F00, 32'h8000_0003);
    // R8 reads
    access(0, 2, 'h1D00, 0);
    access(0, 2, 'h1D04, 0);
    access(0, 2, 'h1F00, 0);
    access(0, 2, 'h1E04, 0);
    // R9 number registers
    access(1, 2, 'h1EDC, 0);
    access(1, 2, 'h1EDC, NSRC);
    access(1, 2, 'h1DDC, NSRC + 1);
    access(1, 2, 'h1FDC, 1);
    idle_check();
    access(0, 2, 'h1FDC, 0);
    // R10 endian variants
    access(1, 2, 'h2004, 32'h0700_0000);
    access(1, 2, 'h2004, 32'h0000_0007);
    access(1, 2, 'h2000, 32'h9);
    access(0, 2, 'h2004, 0);
    // R11 message word
    access(1, 2, 'h3000, 32'hFFFF_FFFF);
    access(0, 2, 'h3000, 0);

    // random mix
    for (int n = 0; n < 800; n++) begin
      int b = bases[$urandom_range(0, 14)];
      int a = b;
      logic [31:0] d = $urandom;
      logic [1:0] s2 = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'd2;
      if (b == 4 || b == 'h3004) a = b + 4 * $urandom_range(0, NSRC);
      else if (b == 'h1C00 || b == 'h1D00 || b == 'h1E00 || b == 'h1F00)
        a = b + 4 * $urandom_range(0, NW);
      if ($urandom_range(0, 9) == 0) a = a + $urandom_range(1, 3);
      if ($urandom_range(0, 19) == 0) a = $urandom_range(0, 'h7FFC);
      if (b == 'h1CDC || b == 'h1DDC || b == 'h1EDC || b == 'h1FDC || b == 'h2000)
        d = $urandom_range(0, NSRC + 2);
      if (b == 'h2004) d = swap4(32'($urandom_range(0, NSRC + 2)));
      access($urandom_range(0, 1), s2, a, d);
      if (n % 50 == 0) idle_check();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule